// File: doc/BRIEF.md
# Column-Strip Sliding Window Buffer

This block turns a stream of packed memory words into a sliding two-dimensional pixel window. Each 32-bit input word carries two 12-bit pixels. The block gathers these pixels into vertical image columns that are 13 pixels tall. It keeps only the four most recent columns, because four is the width of the widest probe. The window therefore never spans a full object silhouette. Each time a column completes and four columns of the current strip are held, a fresh 13×4 window is offered downstream, tagged with the strip's top row and the column index of its newest column.

The stream is ordered as follows. Within a strip, columns run left to right, and each column runs top to bottom. After the last column of a strip, the next strip starts one image row lower. For the default 512×1024 image this gives 500 strips of 1024 columns, and a frame takes 500·1024·13/2 word reads. Because the column height is odd, a word can straddle two columns. Its second pixel is then held and becomes the top of the next column.

The output uses a valid/ready handshake. While a window is held but not accepted, the input is back-pressured so that no pixel is lost. A frame-start flag on an accepted word restarts scanning at the top-left corner.

Top module: `strip_window_buf`

## Requirements
- R1: Within `in_word`, bits [11:0] hold the earlier pixel and bits [27:16] hold the later pixel (in general, bits [PIX_W-1:0] and [WORD_W/2+PIX_W-1:WORD_W/2]). All other bits have no effect on any output.
- R2: Pixels fill each column from top row to bottom row. Columns fill from left to right across a strip. When a column completes on the earlier pixel of a word, the later pixel becomes row 0 of the next column.
- R3: `win_pix` holds WIN_W columns. The pixel at column slot k (0 = oldest, WIN_W-1 = the column just completed) and row r sits at bits [(k*COL_H+r)*PIX_W +: PIX_W].
- R4: `win_valid` rises on the clock edge after the accepted word that completes a column, provided at least WIN_W columns of the current strip (including that one) have then been loaded. A word that completes no column never presents a window.
- R5: With each window, `win_row` gives the image row at the top of the strip and `win_col` gives the image column of the newest column.
- R6: Column history restarts at each strip. The first window of every strip has `win_col` = WIN_W-1 and contains only columns of that strip.
- R7: After the last column of the last strip (top row IMG_ROWS-COL_H), scanning wraps to strip 0, column 0. If that final word completes the column on its earlier pixel, its later pixel is discarded.
- R8: An accepted word with `in_frame_start` high is taken as the first word of a frame. Any partly built column and the strip and column position are discarded.
- R9: While `win_valid` is high and `win_ready` is low, `in_ready` is low, and `win_pix`, `win_row` and `win_col` stay unchanged.
- R10: After reset, `win_valid` is low and `in_ready` is high.
- R11: Once a window is accepted, `win_valid` is low in the next cycle unless the word accepted in that same cycle completes a column that yields a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | WORD_W | Two packed pixels |
| in_frame_start | input | 1 | Word is the first of a frame |
| win_valid | output | 1 | Window outputs are valid |
| win_ready | input | 1 | Downstream accepts the window |
| win_pix | output | WIN_W*COL_H*PIX_W | Window pixels, column-major |
| win_row | output | ROW_W | Top image row of the current strip |
| win_col | output | COLI_W | Image column of the newest window column |

## Verification
The bench builds the block with a 5-pixel column, a 3-column window and a 7×5 image. This gives three strips of five columns and 75 pixels per frame. With that shape, every straddle phase is reached, along with strip changes and the odd leftover pixel at frame end, all within a few dozen words. Five frames are swept, each pixel value derived arithmetically from frame, row and column: frames run with and without frame-start, one frame is aborted mid-strip, and different input-gap and output-stall patterns are applied. Every cycle's outputs are compared against an arithmetic model of the expected window.

// File: rtl/swb_pkg.sv
package swb_pkg;

   // Counter width able to hold values 0 .. n-1 (at least one bit).
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/swb_col_assemble.sv
module swb_col_assemble #(
   parameter  int unsigned PIX_W    = 12,
   parameter  int unsigned COL_H    = 13,
   localparam int unsigned FILL_W   = swb_pkg::cnt_w(COL_H + 1),
   localparam int unsigned COL_BITS = COL_H * PIX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic                restart,
   input  logic [PIX_W-1:0]    pix_lo,
   input  logic [PIX_W-1:0]    pix_hi,
   input  logic                drop_spill,
   output logic                col_done,
   output logic [COL_BITS-1:0] col_flat
);

   localparam logic [FILL_W-1:0] DONE_AT   = FILL_W'(COL_H - 2);
   localparam logic [FILL_W-1:0] LAST_SLOT = FILL_W'(COL_H - 1);

   logic [FILL_W-1:0] fill_q;
   logic [FILL_W-1:0] fill_eff;
   logic [PIX_W-1:0]  slot_q [COL_H];
   logic [PIX_W-1:0]  merged [COL_H];
   logic              spill;

   assign fill_eff = restart ? '0 : fill_q;
   assign col_done = take && (fill_eff >= DONE_AT);

   // Odd column height: a word may straddle two columns.
   generate
      if (COL_H % 2 == 1) begin : g_odd
         assign spill = (fill_eff == LAST_SLOT);
      end else begin : g_even
         assign spill = 1'b0;
      end
   endgenerate

   always_comb begin
      for (int i = 0; i < COL_H; i++) begin
         merged[i] = slot_q[i];
         if (fill_eff == FILL_W'(i))
            merged[i] = pix_lo;
         else if (fill_eff + FILL_W'(1) == FILL_W'(i))
            merged[i] = pix_hi;
      end
   end

   generate
      for (genvar g = 0; g < COL_H; g++) begin : g_flat
         assign col_flat[g*PIX_W +: PIX_W] = merged[g];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q <= '0;
         for (int i = 0; i < COL_H; i++) slot_q[i] <= '0;
      end else if (take) begin
         if (col_done) begin
            if (spill && !drop_spill) begin
               slot_q[0] <= pix_hi;
               fill_q    <= FILL_W'(1);
            end else begin
               fill_q    <= '0;
            end
         end else begin
            for (int i = 0; i < COL_H; i++) slot_q[i] <= merged[i];
            fill_q <= fill_eff + FILL_W'(2);
         end
      end
   end

endmodule

// File: rtl/swb_scan_ctrl.sv
module swb_scan_ctrl #(
   parameter  int unsigned COL_H    = 13,
   parameter  int unsigned WIN_W    = 4,
   parameter  int unsigned IMG_ROWS = 512,
   parameter  int unsigned IMG_COLS = 1024,
   localparam int unsigned STRIPS   = IMG_ROWS - COL_H + 1,
   localparam int unsigned ROW_W    = swb_pkg::cnt_w(STRIPS),
   localparam int unsigned COLI_W   = swb_pkg::cnt_w(IMG_COLS),
   localparam int unsigned LOAD_W   = swb_pkg::cnt_w(WIN_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              restart,
   input  logic              col_done,
   input  logic              out_ready,
   output logic              frame_last,
   output logic              out_valid,
   output logic [ROW_W-1:0]  out_row,
   output logic [COLI_W-1:0] out_col
);

   logic [COLI_W-1:0] col_q, col_eff;
   logic [ROW_W-1:0]  strip_q, strip_eff;
   logic [LOAD_W-1:0] load_q, load_eff;
   logic              last_col, last_strip, full_next;

   assign col_eff    = restart ? '0 : col_q;
   assign strip_eff  = restart ? '0 : strip_q;
   assign load_eff   = restart ? '0 : load_q;
   assign last_col   = (col_eff == COLI_W'(IMG_COLS - 1));
   assign last_strip = (strip_eff == ROW_W'(STRIPS - 1));
   assign frame_last = last_col && last_strip;
   assign full_next  = (load_eff >= LOAD_W'(WIN_W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q     <= '0;
         strip_q   <= '0;
         load_q    <= '0;
         out_valid <= 1'b0;
         out_row   <= '0;
         out_col   <= '0;
      end else if (take) begin
         out_valid <= col_done && full_next;
         if (col_done) begin
            out_row <= strip_eff;
            out_col <= col_eff;
            if (last_col) begin
               col_q   <= '0;
               load_q  <= '0;
               strip_q <= last_strip ? '0 : strip_eff + ROW_W'(1);
            end else begin
               col_q   <= col_eff + COLI_W'(1);
               load_q  <= full_next ? LOAD_W'(WIN_W) : load_eff + LOAD_W'(1);
               strip_q <= strip_eff;
            end
         end else begin
            col_q   <= col_eff;
            strip_q <= strip_eff;
            load_q  <= load_eff;
         end
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/swb_window_regs.sv
module swb_window_regs #(
   parameter  int unsigned PIX_W    = 12,
   parameter  int unsigned COL_H    = 13,
   parameter  int unsigned WIN_W    = 4,
   localparam int unsigned COL_BITS = COL_H * PIX_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      shift,
   input  logic [COL_BITS-1:0]       col_in,
   output logic [WIN_W*COL_BITS-1:0] win_flat
);

   logic [COL_BITS-1:0] cols_q [WIN_W];

   generate
      for (genvar k = 0; k < WIN_W; k++) begin : g_col
         logic [COL_BITS-1:0] src;
         if (k == WIN_W - 1) begin : g_newest
            assign src = col_in;
         end else begin : g_older
            assign src = cols_q[k+1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n)     cols_q[k] <= '0;
            else if (shift) cols_q[k] <= src;
         end
         assign win_flat[k*COL_BITS +: COL_BITS] = cols_q[k];
      end
   endgenerate

endmodule

// File: rtl/strip_window_buf.sv
module strip_window_buf #(
   parameter  int unsigned PIX_W    = 12,
   parameter  int unsigned WORD_W   = 32,
   parameter  int unsigned COL_H    = 13,
   parameter  int unsigned WIN_W    = 4,
   parameter  int unsigned IMG_ROWS = 512,
   parameter  int unsigned IMG_COLS = 1024,
   localparam int unsigned ROW_W    = swb_pkg::cnt_w(IMG_ROWS - COL_H + 1),
   localparam int unsigned COLI_W   = swb_pkg::cnt_w(IMG_COLS),
   localparam int unsigned WIN_BITS = WIN_W * COL_H * PIX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [WORD_W-1:0]   in_word,
   input  logic                in_frame_start,
   output logic                win_valid,
   input  logic                win_ready,
   output logic [WIN_BITS-1:0] win_pix,
   output logic [ROW_W-1:0]    win_row,
   output logic [COLI_W-1:0]   win_col
);

   generate
      if (PIX_W > WORD_W / 2) begin : g_bad_pix
         $error("strip_window_buf: two pixels must fit in one word");
      end
      if (COL_H < 3) begin : g_bad_h
         $error("strip_window_buf: column height must be at least 3");
      end
      if (WIN_W < 1 || WIN_W > IMG_COLS) begin : g_bad_w
         $error("strip_window_buf: window width out of range");
      end
      if (IMG_ROWS < COL_H) begin : g_bad_rows
         $error("strip_window_buf: image shorter than one column");
      end
   endgenerate

   logic                  acc, restart, col_done, frame_last;
   logic [PIX_W-1:0]      pix_lo, pix_hi;
   logic [COL_H*PIX_W-1:0] col_flat;
   logic                  unused_bits;

   assign in_ready    = !win_valid || win_ready;
   assign acc         = in_valid && in_ready;
   assign restart     = acc && in_frame_start;
   assign pix_lo      = in_word[PIX_W-1:0];
   assign pix_hi      = in_word[WORD_W/2 +: PIX_W];
   assign unused_bits = ^in_word;

   swb_col_assemble #(.PIX_W(PIX_W), .COL_H(COL_H)) u_asm (
      .clk(clk), .rst_n(rst_n), .take(acc), .restart(restart),
      .pix_lo(pix_lo), .pix_hi(pix_hi), .drop_spill(frame_last),
      .col_done(col_done), .col_flat(col_flat)
   );

   swb_scan_ctrl #(.COL_H(COL_H), .WIN_W(WIN_W), .IMG_ROWS(IMG_ROWS),
                   .IMG_COLS(IMG_COLS)) u_ctl (
      .clk(clk), .rst_n(rst_n), .take(acc), .restart(restart),
      .col_done(col_done), .out_ready(win_ready), .frame_last(frame_last),
      .out_valid(win_valid), .out_row(win_row), .out_col(win_col)
   );

   swb_window_regs #(.PIX_W(PIX_W), .COL_H(COL_H), .WIN_W(WIN_W)) u_win (
      .clk(clk), .rst_n(rst_n), .shift(col_done), .col_in(col_flat),
      .win_flat(win_pix)
   );

endmodule

// File: rtl/swb_checker.sv
module swb_checker #(
   parameter  int unsigned PIX_W    = 12,
   parameter  int unsigned WORD_W   = 32,
   parameter  int unsigned COL_H    = 13,
   parameter  int unsigned WIN_W    = 4,
   parameter  int unsigned IMG_ROWS = 512,
   parameter  int unsigned IMG_COLS = 1024,
   localparam int unsigned STRIPS   = IMG_ROWS - COL_H + 1,
   localparam int unsigned ROW_W    = swb_pkg::cnt_w(STRIPS),
   localparam int unsigned COLI_W   = swb_pkg::cnt_w(IMG_COLS),
   localparam int unsigned WIN_BITS = WIN_W * COL_H * PIX_W
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                win_valid,
   input logic                win_ready,
   input logic [WIN_BITS-1:0] win_pix,
   input logic [ROW_W-1:0]    win_row,
   input logic [COLI_W-1:0]   win_col
);

   // R9
   stall_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_ready) |-> !in_ready);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && !win_ready) |=>
         (win_valid && $stable(win_pix) && $stable(win_row) && $stable(win_col)));

   // R4
   window_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_valid) |-> $past(in_valid && in_ready));

   // R6
   col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_col >= COLI_W'(WIN_W - 1)) && (win_col <= COLI_W'(IMG_COLS - 1)));

   // R5
   row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_row <= ROW_W'(STRIPS - 1)));

endmodule

bind strip_window_buf swb_checker #(
   .PIX_W(PIX_W), .WORD_W(WORD_W), .COL_H(COL_H), .WIN_W(WIN_W),
   .IMG_ROWS(IMG_ROWS), .IMG_COLS(IMG_COLS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .win_valid(win_valid), .win_ready(win_ready), .win_pix(win_pix),
   .win_row(win_row), .win_col(win_col)
);

// File: tb/tb_strip_window_buf.sv
module tb_strip_window_buf;

   localparam int PIX_W    = 12;
   localparam int WORD_W   = 32;
   localparam int COL_H    = 5;
   localparam int WIN_W    = 3;
   localparam int IMG_ROWS = 7;
   localparam int IMG_COLS = 5;
   localparam int STRIPS   = IMG_ROWS - COL_H + 1;
   localparam int FPIX     = STRIPS * IMG_COLS * COL_H;
   localparam int FWORDS   = (FPIX + 1) / 2;
   localparam int ROW_W    = swb_pkg::cnt_w(STRIPS);
   localparam int COLI_W   = swb_pkg::cnt_w(IMG_COLS);
   localparam int WIN_BITS = WIN_W * COL_H * PIX_W;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                in_valid, in_ready, in_frame_start;
   logic [WORD_W-1:0]   in_word;
   logic                win_valid, win_ready;
   logic [WIN_BITS-1:0] win_pix;
   logic [ROW_W-1:0]    win_row;
   logic [COLI_W-1:0]   win_col;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit mv = 1'b0;
   int mf = 0, ms = 0, mc = 0;

   always #5 clk = ~clk;

   strip_window_buf #(.PIX_W(PIX_W), .WORD_W(WORD_W), .COL_H(COL_H), .WIN_W(WIN_W),
                      .IMG_ROWS(IMG_ROWS), .IMG_COLS(IMG_COLS)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .in_frame_start(in_frame_start), .win_valid(win_valid),
      .win_ready(win_ready), .win_pix(win_pix), .win_row(win_row), .win_col(win_col)
   );

   function automatic logic [PIX_W-1:0] img(int f, int y, int x);
      return PIX_W'((f * 300 + y * 16 + x + 5) % 4096);
   endfunction

   // Pixel at stream position p: strip-major, then column, then row (R2)
   function automatic logic [PIX_W-1:0] pix_at(int f, int p);
      int g = p / COL_H;
      int r = p % COL_H;
      return img(f, g / IMG_COLS + r, g % IMG_COLS);
   endfunction

   // R1: junk in the unused nibbles
   function automatic logic [WORD_W-1:0] word_of(int f, int w);
      logic [PIX_W-1:0] p1;
      p1 = (2 * w + 1 < FPIX) ? pix_at(f, 2 * w + 1) : 12'hEEE;
      return {4'(w + 9), p1, 4'hC ^ 4'(f), pix_at(f, 2 * w)};
   endfunction

   function automatic bit exp_win(int w, output int s, output int c);
      s = 0; c = 0;
      for (int p = 2 * w; p <= 2 * w + 1; p++) begin
         if (p < FPIX && (p % COL_H) == COL_H - 1) begin
            s = (p / COL_H) / IMG_COLS;
            c = (p / COL_H) % IMG_COLS;
            return (c >= WIN_W - 1);
         end
      end
      return 1'b0;
   endfunction

   // R3 layout
   function automatic logic [WIN_BITS-1:0] win_exp(int f, int s, int c);
      logic [WIN_BITS-1:0] v = '0;
      for (int k = 0; k < WIN_W; k++)
         for (int r = 0; r < COL_H; r++)
            v[(k * COL_H + r) * PIX_W +: PIX_W] = img(f, s + r, c - (WIN_W - 1) + k);
      return v;
   endfunction

   task automatic compare();
      string tag;
      n_tests++;
      if (win_valid !== mv) begin
         n_fail++;
         $display("FAIL R4/R11 win_valid actual=%0b expected=%0b (cycle %0d)", win_valid, mv, cyc);
      end
      if (mv) begin
         tag = (mf == 3) ? "R8" : (mf == 1) ? "R7" : (mc == WIN_W - 1 && ms > 0) ? "R6" : "R3";
         n_tests++;
         if (win_pix !== win_exp(mf, ms, mc)) begin
            n_fail++;
            $display("FAIL %s/R1/R2 win_pix actual=%h expected=%h", tag, win_pix, win_exp(mf, ms, mc));
         end
         n_tests++;
         if (win_row !== ROW_W'(ms) || win_col !== COLI_W'(mc)) begin
            n_fail++;
            $display("FAIL R5 row/col actual=%0d/%0d expected=%0d/%0d", win_row, win_col, ms, mc);
         end
      end
   endtask

   task automatic run_frame(int f, int nwords, bit use_fs, int mode);
      int w = 0;
      int s, c;
      bit acc;
      while (w < nwords) begin
         @(negedge clk);
         cyc++;
         compare();
         win_ready      = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 0) : (cyc % 5 >= 2);
         in_valid       = (mode == 0) ? 1'b1 : (cyc % 4 != 1);
         in_word        = word_of(f, w);
         in_frame_start = use_fs && (w == 0);
         #1;
         if (win_valid && !win_ready) begin
            n_tests++;
            if (in_ready !== 1'b0) begin
               n_fail++;
               $display("FAIL R9 in_ready during stall actual=%0b expected=0", in_ready);
            end
         end
         acc = in_valid && in_ready;
         if (acc) begin
            mv = exp_win(w, s, c);
            if (mv) begin mf = f; ms = s; mc = c; end
            w++;
         end else if (win_ready) begin
            mv = 1'b0;
         end
      end
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_frame_start = 1'b0; win_ready = 1'b0;
      repeat (3) @(negedge clk);
      // R10
      n_tests++;
      if (win_valid !== 1'b0 || in_ready !== 1'b1) begin
         n_fail++;
         $display("FAIL R10 reset valid/ready actual=%0b/%0b expected=0/1", win_valid, in_ready);
      end
      rst_n = 1'b1;
      run_frame(0, FWORDS, 1'b1, 0);
      run_frame(1, FWORDS, 1'b0, 1);   // R7 wrap without frame start
      run_frame(2, 17, 1'b1, 2);       // aborted mid-strip
      run_frame(3, FWORDS, 1'b1, 1);   // R8 restart
      run_frame(4, FWORDS, 1'b0, 2);
      repeat (6) begin
         @(negedge clk);
         cyc++;
         compare();
         in_valid = 1'b0; in_frame_start = 1'b0; win_ready = 1'b1;
         #1;
         mv = 1'b0;
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog expired: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule